// File: doc/BRIEF.md
# Multi-Bank GPIO Port Register File

This block is a word-addressed register file that holds the configuration and output state of several GPIO pin banks and turns that state directly into pad control signals. Each bank has up to 32 pins and a fixed group of nine 32-bit words. The group holds the per-pin direction and function codes, one data word, and the drive-strength and pull-resistor codes. The three kinds of configuration field are packed at different densities: a function word covers eight pins, while a drive or pull word covers sixteen.

Software or a bus bridge drives the word address, write strobe and write data. Read data is combinational from the address. The block drives the output value and output enable of every pin, passes each pin's 2-bit drive and pull codes out unchanged, and samples the pad inputs through a two-flop synchronizer. A single write to a bank's data word updates every output latch of that bank on the same clock edge.

Top module: `gpio_bank_regs`

## Requirements
- R1: Bank b occupies word addresses 9*b to 9*b+8. Words 0..3 of the group are function words, word 4 is the data word, words 5..6 are drive words and words 7..8 are pull words. This corresponds to byte offsets 0x00, 0x10, 0x14 and 0x1C within a 0x24-byte stride. A word address at or above 9*NUM_BANKS reads as 0, and a write to it changes no register.
- R2: Pin p's function code sits in bits [(p%8)*4+2 : (p%8)*4] of function word p/8. The fourth bit of each 4-bit slot always reads 0.
- R3: A function code of 1 turns on the pin's output enable. Code 0 (input) and codes 2..7 (other functions) turn it off. The new enable appears one clock after the write.
- R4: Pin p's drive code and pull code sit in bits [(p%16)*2+1 : (p%16)*2] of drive word p/16 and pull word p/16. These codes appear on pad_drive and pad_pull at bits 2*(b*PINS+p).
- R5: A write to the data word loads every output latch of the bank at once. pad_out shows the new value one clock after the write.
- R6: A data-word read returns the output latch for pins with function code 1. For all other pins it returns the pad input after a two-flop synchronizer, which becomes visible after two clock edges.
- R7: After reset, every function code is 0, every pull code is 0 (no pull, with 1 = pull-up and 2 = pull-down), every drive code is 1 and every output latch is 0.
- R8: Slots for pins at or above PINS_PER_BANK read as 0 and ignore writes in every word. This includes function word 3 when fewer than 25 pins exist.
- R9: A write to one bank leaves the registers and pad outputs of every other bank unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Word address |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pad_in | input | NUM_BANKS*PINS_PER_BANK | Raw pad inputs, bank-major |
| pad_out | output | NUM_BANKS*PINS_PER_BANK | Output latch per pin |
| pad_oe | output | NUM_BANKS*PINS_PER_BANK | Output enable per pin |
| pad_drive | output | NUM_BANKS*PINS_PER_BANK*2 | Drive-strength code per pin |
| pad_pull | output | NUM_BANKS*PINS_PER_BANK*2 | Pull-resistor code per pin |

## Verification
The hardest cases to reach are the partially populated words. These are slots of pins beyond the bank width that sit inside real function, drive and pull words, and they can only be reached when PINS_PER_BANK is not a multiple of 8 or 16. The bench therefore builds the block with 20 pins per bank. It writes all-ones patterns into the third and fourth function words and into the upper pull word, then checks that only the slots of existing pins read back. The data-word read mixes latches and synchronized inputs per pin. The bench sets a mixed direction pattern, changes pad_in, and reads the data word after one edge and again after two edges to observe the synchronizer depth.

// File: rtl/gpio_mb_pkg.sv
package gpio_mb_pkg;
   // Word layout of one bank group (nine words, 0x24 bytes)
   localparam int        WORDS_PER_BANK = 9;
   localparam logic [3:0] OFF_FN_LAST   = 4'd3;
   localparam logic [3:0] OFF_DATA      = 4'd4;
   localparam logic [3:0] OFF_DRV0      = 4'd5;
   localparam logic [3:0] OFF_DRV1      = 4'd6;
   localparam logic [3:0] OFF_PUL0      = 4'd7;
   localparam logic [3:0] OFF_PUL1      = 4'd8;

   typedef logic [2:0] fn_code_t;
   typedef logic [1:0] pad_code_t;

   localparam fn_code_t  FN_INPUT   = 3'd0;
   localparam fn_code_t  FN_OUTPUT  = 3'd1;
   localparam pad_code_t DRV_RESET  = 2'd1;
   localparam pad_code_t PULL_RESET = 2'd0;
endpackage

// File: rtl/gpio_mb_sync.sv
module gpio_mb_sync #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stage1_q;
   logic [1:0]   since_rst_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage1_q <= '0;
         q        <= '0;
      end else begin
         stage1_q <= d;
         q        <= stage1_q;
      end
   end

   // cycles since reset, saturating, used only to bound the look-back
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 since_rst_q <= 2'd0;
      else if (since_rst_q != 2'd2) since_rst_q <= since_rst_q + 2'd1;
   end

   // R6: synchronized value is the input seen two edges earlier
   a_r6_two_flop_delay: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst_q == 2'd2) |-> (q == $past(d, 2)));
endmodule

// File: rtl/gpio_mb_field.sv
// Array of per-pin codes packed SLOTS to a 32-bit word, SLOT_W bits per slot,
// FW meaningful bits per slot. Slots of absent pins read 0.
module gpio_mb_field #(
   parameter int             PINS   = 32,
   parameter int             FW     = 3,
   parameter int             SLOT_W = 4,
   parameter int             SLOTS  = 8,
   parameter int             NWORDS = 4,
   parameter logic [FW-1:0]  RST    = '0,
   localparam int            IDX_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_word,
   input  logic [31:0]        wdata,
   input  logic [IDX_W-1:0]   rd_word,
   output logic [31:0]        rd_data,
   output logic [PINS*FW-1:0] fields
);
   if (SLOTS * SLOT_W != 32) begin : g_bad_pack
      $error("gpio_mb_field: SLOTS*SLOT_W must be 32");
   end
   if (FW > SLOT_W) begin : g_bad_width
      $error("gpio_mb_field: FW exceeds SLOT_W");
   end
   if (PINS > SLOTS * NWORDS) begin : g_bad_words
      $error("gpio_mb_field: too few words for PINS");
   end

   logic [PINS*FW-1:0] fld_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fld_q <= {PINS{RST}};
      end else if (wr_en) begin
         for (int p = 0; p < PINS; p++) begin
            if (IDX_W'(p / SLOTS) == wr_word)
               fld_q[p*FW +: FW] <= wdata[(p % SLOTS)*SLOT_W +: FW];
         end
      end
   end

   always_comb begin
      rd_data = '0;
      for (int p = 0; p < PINS; p++) begin
         if (IDX_W'(p / SLOTS) == rd_word)
            rd_data[(p % SLOTS)*SLOT_W +: FW] = fld_q[p*FW +: FW];
      end
   end

   assign fields = fld_q;
endmodule

// File: rtl/gpio_mb_bank.sv
module gpio_mb_bank
   import gpio_mb_pkg::*;
#(
   parameter int PINS   = 32,
   parameter int ADDR_W = 8,
   parameter int BASE   = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_we,
   input  logic [31:0]        bus_wdata,
   input  logic [PINS-1:0]    in_sync,
   output logic [31:0]        rdata,
   output logic [PINS-1:0]    pin_out,
   output logic [PINS-1:0]    pin_oe,
   output logic [PINS*2-1:0]  pin_drive,
   output logic [PINS*2-1:0]  pin_pull
);
   localparam int AW1 = ADDR_W + 1;

   logic [AW1-1:0] rel;
   logic           sel;
   logic [3:0]     off;

   assign rel = {1'b0, bus_addr} - AW1'(BASE);
   assign sel = ({1'b0, bus_addr} >= AW1'(BASE)) && (rel < AW1'(WORDS_PER_BANK));
   assign off = rel[3:0];

   logic wr;
   logic fn_wr, dat_wr, drv_wr, pul_wr;
   assign wr     = bus_we && sel;
   assign fn_wr  = wr && (off <= OFF_FN_LAST);
   assign dat_wr = wr && (off == OFF_DATA);
   assign drv_wr = wr && ((off == OFF_DRV0) || (off == OFF_DRV1));
   assign pul_wr = wr && ((off == OFF_PUL0) || (off == OFF_PUL1));

   logic [31:0]       fn_rd, drv_rd, pul_rd;
   logic [PINS*3-1:0] fn_flat;

   gpio_mb_field #(.PINS(PINS), .FW(3), .SLOT_W(4), .SLOTS(8), .NWORDS(4),
                   .RST(FN_INPUT)) u_fn (
      .clk(clk), .rst_n(rst_n), .wr_en(fn_wr), .wr_word(off[1:0]),
      .wdata(bus_wdata), .rd_word(off[1:0]), .rd_data(fn_rd), .fields(fn_flat));

   gpio_mb_field #(.PINS(PINS), .FW(2), .SLOT_W(2), .SLOTS(16), .NWORDS(2),
                   .RST(DRV_RESET)) u_drv (
      .clk(clk), .rst_n(rst_n), .wr_en(drv_wr), .wr_word(off == OFF_DRV1),
      .wdata(bus_wdata), .rd_word(off == OFF_DRV1), .rd_data(drv_rd),
      .fields(pin_drive));

   gpio_mb_field #(.PINS(PINS), .FW(2), .SLOT_W(2), .SLOTS(16), .NWORDS(2),
                   .RST(PULL_RESET)) u_pul (
      .clk(clk), .rst_n(rst_n), .wr_en(pul_wr), .wr_word(off == OFF_PUL1),
      .wdata(bus_wdata), .rd_word(off == OFF_PUL1), .rd_data(pul_rd),
      .fields(pin_pull));

   // Output latches: one write updates all pins of the bank together
   logic [PINS-1:0] lat_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      lat_q <= '0;
      else if (dat_wr) lat_q <= bus_wdata[PINS-1:0];
   end
   assign pin_out = lat_q;

   logic [PINS-1:0] dat_view;
   for (genvar p = 0; p < PINS; p++) begin : g_pin
      assign pin_oe[p]   = (fn_flat[p*3 +: 3] == FN_OUTPUT);
      assign dat_view[p] = pin_oe[p] ? lat_q[p] : in_sync[p];
   end

   always_comb begin
      rdata = '0;
      if (sel) begin
         if (off <= OFF_FN_LAST)                        rdata = fn_rd;
         else if (off == OFF_DATA)                      rdata = 32'(dat_view);
         else if (off == OFF_DRV0 || off == OFF_DRV1)   rdata = drv_rd;
         else                                           rdata = pul_rd;
      end
   end

   // R5: all latches take the written word on the following edge
   a_r5_data_word_load: assert property (@(posedge clk) disable iff (!rst_n)
      dat_wr |=> (pin_out == $past(bus_wdata[PINS-1:0])));

   // R3: slot 0 code decides pin 0 output enable one clock after the write
   a_r3_oe_after_fn_write: assert property (@(posedge clk) disable iff (!rst_n)
      (fn_wr && off == 4'd0) |=> (pin_oe[0] == ($past(bus_wdata[2:0]) == FN_OUTPUT)));

   // R1/R9: no write addressed here leaves every register of this bank unchanged
   a_r9_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> $stable({fn_flat, pin_drive, pin_pull, lat_q}));
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
   import gpio_mb_pkg::*;
#(
   parameter int NUM_BANKS     = 4,
   parameter int PINS_PER_BANK = 32,
   parameter int ADDR_W        = 8,
   localparam int NPIN         = NUM_BANKS * PINS_PER_BANK,
   localparam int TOTAL_WORDS  = NUM_BANKS * WORDS_PER_BANK
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [NPIN-1:0]   pad_in,
   output logic [NPIN-1:0]   pad_out,
   output logic [NPIN-1:0]   pad_oe,
   output logic [NPIN*2-1:0] pad_drive,
   output logic [NPIN*2-1:0] pad_pull
);
   if (PINS_PER_BANK < 1 || PINS_PER_BANK > 32) begin : g_bad_pins
      $error("gpio_bank_regs: PINS_PER_BANK must be 1..32");
   end
   if (NUM_BANKS < 1) begin : g_bad_banks
      $error("gpio_bank_regs: NUM_BANKS must be at least 1");
   end
   if (ADDR_W < 4 || TOTAL_WORDS > (1 << ADDR_W)) begin : g_bad_addr
      $error("gpio_bank_regs: ADDR_W too narrow for the bank groups");
   end

   logic [NPIN-1:0] in_sync;

   gpio_mb_sync #(.W(NPIN)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pad_in), .q(in_sync));

   logic [31:0] bank_rd [NUM_BANKS];

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      gpio_mb_bank #(
         .PINS(PINS_PER_BANK), .ADDR_W(ADDR_W), .BASE(b * WORDS_PER_BANK)
      ) u_bank (
         .clk       (clk),
         .rst_n     (rst_n),
         .bus_addr  (bus_addr),
         .bus_we    (bus_we),
         .bus_wdata (bus_wdata),
         .in_sync   (in_sync[b*PINS_PER_BANK +: PINS_PER_BANK]),
         .rdata     (bank_rd[b]),
         .pin_out   (pad_out[b*PINS_PER_BANK +: PINS_PER_BANK]),
         .pin_oe    (pad_oe[b*PINS_PER_BANK +: PINS_PER_BANK]),
         .pin_drive (pad_drive[b*PINS_PER_BANK*2 +: PINS_PER_BANK*2]),
         .pin_pull  (pad_pull[b*PINS_PER_BANK*2 +: PINS_PER_BANK*2])
      );
   end

   always_comb begin
      bus_rdata = '0;
      for (int b = 0; b < NUM_BANKS; b++) bus_rdata = bus_rdata | bank_rd[b];
   end

   // R1: addresses past the last bank group return zero
   a_r1_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, bus_addr} >= (ADDR_W+1)'(TOTAL_WORDS)) |-> (bus_rdata == 32'd0));
endmodule

// File: tb/tb_gpio_bank_regs.sv
module tb_gpio_bank_regs;
   localparam int NB = 3;
   localparam int P  = 20;
   localparam int AW = 8;
   localparam int N  = NB * P;

   localparam int SRC_RD = 0, SRC_OE = 1, SRC_OUT = 2, SRC_DRV_LO = 3, SRC_PUL_HI = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [AW-1:0]   bus_addr = '0;
   logic            bus_we = 1'b0;
   logic [31:0]     bus_wdata = '0;
   logic [31:0]     bus_rdata;
   logic [N-1:0]    pad_in = '0;
   logic [N-1:0]    pad_out, pad_oe;
   logic [N*2-1:0]  pad_drive, pad_pull;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   gpio_bank_regs #(.NUM_BANKS(NB), .PINS_PER_BANK(P), .ADDR_W(AW)) dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe), .pad_drive(pad_drive), .pad_pull(pad_pull));

   typedef struct {
      int          src;
      int          bank;
      logic [31:0] exp;
      string       tag;
   } item_t;

   item_t sb[$];

   // monitor: pops one expected item per falling edge and compares
   always @(negedge clk) begin
      if (sb.size() > 0) begin
         item_t it;
         logic [31:0] act;
         it = sb.pop_front();
         case (it.src)
            SRC_RD:     act = bus_rdata;
            SRC_OE:     act = 32'(pad_oe[it.bank*P +: P]);
            SRC_OUT:    act = 32'(pad_out[it.bank*P +: P]);
            SRC_DRV_LO: act = pad_drive[it.bank*P*2 +: 32];
            default:    act = 32'(pad_pull[it.bank*P*2 + 32 +: 8]);
         endcase
         checks++;
         if (act !== it.exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
         end
      end
   end

   task automatic wr(input int addr, input logic [31:0] data);
      @(posedge clk); #2;
      bus_addr = AW'(addr); bus_wdata = data; bus_we = 1'b1;
      @(posedge clk); #2;
      bus_we = 1'b0;
   endtask

   task automatic expect_rd(input int addr, input logic [31:0] exp, input string tag);
      item_t it;
      @(posedge clk); #2;
      bus_addr = AW'(addr);
      it.src = SRC_RD; it.bank = 0; it.exp = exp; it.tag = tag;
      sb.push_back(it);
   endtask

   task automatic expect_pad(input int src, input int bank, input logic [31:0] exp,
                             input string tag);
      item_t it;
      @(posedge clk); #2;
      it.src = src; it.bank = bank; it.exp = exp; it.tag = tag;
      sb.push_back(it);
   endtask

   task automatic set_pads(input int bank, input logic [P-1:0] v);
      @(posedge clk); #2;
      pad_in[bank*P +: P] = v;
   endtask

   task automatic report();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      #2_000_000;
      if (!finished) begin
         failures++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         report();
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;

      // R7 reset state
      expect_rd(0, 32'h0, "R7 func word reset");
      expect_rd(4, 32'h0, "R7 data word reset");
      expect_rd(5, 32'h5555_5555, "R7 drive word0 reset");
      expect_rd(6, 32'h0000_0055, "R8 R7 drive word1 only 4 pins");
      expect_rd(7, 32'h0, "R7 pull word reset");
      expect_pad(SRC_OE, 0, 32'h0, "R7 oe reset");
      expect_pad(SRC_OUT, 1, 32'h0, "R7 latch reset");

      // R2/R3 function packing: slots 1,2,7(F masked),1; upper slots 8 -> 0
      wr(0, 32'h8888_1F21);
      expect_rd(0, 32'h0000_1721, "R2 func slot packing");
      expect_pad(SRC_OE, 0, 32'h0000_0009, "R3 oe only for code 1");

      // R5 data word sets all latches together
      wr(4, 32'hFFFF_FFFF);
      expect_pad(SRC_OUT, 0, 32'h000F_FFFF, "R5 R8 latch load");
      expect_rd(4, 32'h0000_0009, "R6 mixed data read");

      // R6 synchronizer depth (pin 1 is an alternate-function pin)
      set_pads(0, 20'h000F2);
      expect_rd(4, 32'h0000_0009, "R6 input not yet after one edge");
      expect_rd(4, 32'h0000_00FB, "R6 input after two edges");

      // R8 partial function words
      wr(2, 32'h1111_1111);
      expect_rd(2, 32'h0000_1111, "R8 func word2 absent pins");
      expect_pad(SRC_OE, 0, 32'h000F_0009, "R3 oe upper pins");
      expect_rd(4, 32'h000F_00FB, "R6 latch for new outputs");
      wr(3, 32'hFFFF_FFFF);
      expect_rd(3, 32'h0, "R8 func word3 all absent");

      // R4 drive and pull fields
      wr(5, 32'h0000_00E4);
      expect_rd(5, 32'h0000_00E4, "R4 drive readback");
      expect_pad(SRC_DRV_LO, 0, 32'h0000_00E4, "R4 drive pad codes");
      wr(8, 32'hFFFF_FF06);
      expect_rd(8, 32'h0000_0006, "R4 R8 pull word1 readback");
      expect_pad(SRC_PUL_HI, 0, 32'h0000_0006, "R4 pull pad codes");
      expect_rd(6, 32'h0000_0055, "R4 other drive word untouched");

      // R9 bank independence
      wr(9, 32'h1111_1111);
      wr(13, 32'h0001_2345);
      expect_pad(SRC_OE, 1, 32'h0000_00FF, "R9 bank1 oe");
      expect_pad(SRC_OE, 0, 32'h000F_0009, "R9 bank0 oe kept");
      expect_pad(SRC_OE, 2, 32'h0, "R9 bank2 oe kept");
      expect_pad(SRC_OUT, 1, 32'h0001_2345, "R9 R5 bank1 latch");
      expect_pad(SRC_OUT, 0, 32'h000F_FFFF, "R9 bank0 latch kept");
      expect_rd(13, 32'h0000_0045, "R9 R6 bank1 data read");

      // R1 unmapped addresses
      wr(30, 32'hFFFF_FFFF);
      wr(27, 32'hFFFF_FFFF);
      expect_rd(30, 32'h0, "R1 unmapped read");
      expect_rd(27, 32'h0, "R1 first address past banks");
      expect_rd(0, 32'h0000_1721, "R1 bank0 after unmapped write");
      expect_rd(18, 32'h0, "R1 bank2 func after unmapped write");
      expect_rd(23, 32'h5555_5555, "R1 bank2 drive after unmapped write");
      expect_rd(26, 32'h0, "R1 bank2 pull after unmapped write");
      expect_pad(SRC_OUT, 2, 32'h0, "R1 bank2 latch after unmapped write");

      repeat (3) @(posedge clk);
      finished = 1'b1;
      report();
   end
endmodule